// File: doc/BRIEF.md
# Nested-Loop DMA Channel Engine

This block is one DMA channel that copies data between two address ranges without help from a processor. It is built as two nested counters. The inner counter walks through the words of one burst. The outer counter walks through the bursts of one transfer. A single trigger, from a peripheral strobe or from a software bit, moves exactly one burst. Once a burst has started it runs to its end on its own. The last burst of a transfer raises a one-cycle completion interrupt.

Each word is moved by a read followed by a write on a simple memory-style master port. Read data comes back one cycle after the read strobe, or two cycles after it when the source is flagged as slow. The source and destination pointers are updated next to the counters. Each pointer has a signed step applied between the words of a burst, and a separate signed step applied after the last word of a burst. Configuration arrives on plain register inputs and must stay stable while the channel is busy. When a new transfer starts, the pointers are reloaded from the base addresses.

Top module: `dma_nest_chan`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `mem_rd_en`, `mem_wr_en`, `trig_ovf` and `xfer_done_irq` are all 0.
- R2: If `periph_trig` or `sw_trig` is high at a clock edge while the channel is idle, `busy` rises after that edge. It is followed by one cycle with no bus strobe, and then the first read strobe.
- R3: One trigger moves exactly `cfg_burst_m1`+1 words, which is 1 to 32. No further trigger is needed.
- R4: With a normal source, each word takes 4 cycles, in this order: a cycle with `mem_rd_en`, one wait cycle, a cycle with `mem_wr_en`, and one advance cycle. The read and write strobes are never high together.
- R5: With `cfg_slow_src`=1, each word takes 5 cycles because there are two wait cycles between the read and the write. The write strobe comes 3 cycles after the read strobe.
- R6: `mem_size` equals `cfg_wide` on every strobe (1 means 32-bit, 0 means 16-bit). In 16-bit mode, `mem_wdata[31:16]` is 0 and bits 15:0 carry the low half of the word that was read.
- R7: Reads use the source pointer and writes use the destination pointer. After every word except the last of a burst, each pointer adds its signed word step. After the last word of a burst, each pointer adds its signed burst step instead of the word step. Both steps are two's complement.
- R8: A transfer is `cfg_xfer_m1`+1 bursts long. The burst after the final one starts a new transfer at `cfg_src_base` and `cfg_dst_base`.
- R9: `xfer_done_irq` is a one-cycle pulse. It appears in the cycle after the advance cycle of the final word of the final burst of a transfer.
- R10: A trigger that arrives while the channel is busy is held as pending. When the current burst ends, the pending trigger starts the next burst at once, through the idle gap cycle. A trigger present at the final advance cycle also starts the next burst directly.
- R11: A trigger that arrives while one is already pending is dropped. It produces a one-cycle `trig_ovf` pulse in the next cycle.
- R12: The data written for each word equals the data returned by the read of that same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | Word size: 1 = 32-bit, 0 = 16-bit |
| cfg_slow_src | input | 1 | Source needs an extra read wait cycle |
| cfg_burst_m1 | input | 5 | Words per burst minus one |
| cfg_xfer_m1 | input | 16 | Bursts per transfer minus one |
| cfg_src_base | input | 32 | Source start address |
| cfg_dst_base | input | 32 | Destination start address |
| cfg_src_wstep | input | 16 | Signed source step between words |
| cfg_dst_wstep | input | 16 | Signed destination step between words |
| cfg_src_bstep | input | 16 | Signed source step after a burst |
| cfg_dst_bstep | input | 16 | Signed destination step after a burst |
| periph_trig | input | 1 | Peripheral trigger, sampled at each edge |
| sw_trig | input | 1 | Software trigger bit, sampled at each edge |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_size | output | 1 | Access size: 1 = 32-bit |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data (1-cycle latency, or 2 when slow) |
| busy | output | 1 | A burst is in progress |
| trig_ovf | output | 1 | One-cycle pulse: a trigger was dropped |
| xfer_done_irq | output | 1 | One-cycle pulse: the transfer is complete |

## Verification
The bench reads the triggers at each rising edge. At that same edge it expands every burst it accepts into a queue of expected per-cycle bus states. The queue starts with one idle gap cycle. Each word then adds a read cycle, one or two wait cycles, a write cycle and an advance cycle. The first read therefore falls two cycles after the triggering edge. Each write falls two cycles after its read, or three with a slow source. The interrupt and the overflow pulse are expected exactly one cycle after the edge that caused them: the final advance cycle for the interrupt, and the excess trigger for the overflow. Every comparison is made at the falling edge, so every register on the path has already updated. Stimulus is changed at falling edges only.

// File: rtl/dma_nest_pkg.sv
// Shared types for the nested-loop DMA channel.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_nest_pkg;

    localparam int WIDE_W   = 32;
    localparam int NARROW_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_ADV
    } chan_st_e;

endpackage

// File: rtl/dma_nest_dcnt.sv
// Loadable down counter with a zero flag, used for both loop levels.
// Assumes: load has priority over dec; the count stops at zero.
module dma_nest_dcnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         at_zero
);

    logic [W-1:0] cnt_q;

    // remaining-count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/dma_nest_agen.sv
// One address pointer: loads a base, then adds a signed step per word,
// or the signed burst step on the last word of a burst.
// Assumes: SW <= AW; the step is sign-extended to AW bits.
module dma_nest_agen #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 adv,
    input  logic                 burst_end,
    input  logic [AW-1:0]        base,
    input  logic signed [SW-1:0] word_step,
    input  logic signed [SW-1:0] burst_step,
    output logic [AW-1:0]        ptr
);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] step_x;

    // pick the step that applies to this advance
    always_comb step_x = burst_end ? AW'(burst_step) : AW'(word_step);

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= base;
        else if (adv)
            ptr_q <= ptr_q + step_x;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/dma_nest_trig.sv
// Trigger bookkeeping: holds one pending trigger while busy and flags
// any trigger that finds one already pending.
// Assumes: take is high in the cycle a burst is launched.
module dma_nest_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic busy,
    input  logic take,
    output logic pend,
    output logic ovf
);

    logic pend_q;
    logic ovf_q;

    // pending flag: cleared by a launch, set by a trigger while busy
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (take)
            pend_q <= 1'b0;
        else if (ev && busy)
            pend_q <= 1'b1;
    end

    // overflow pulse, one cycle after the excess trigger
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else
            ovf_q <= ev && pend_q;
    end

    assign pend = pend_q;
    assign ovf  = ovf_q;

endmodule

// File: rtl/dma_nest_chan.sv
// Single DMA channel: word loop inside burst loop, one burst per trigger,
// read-then-write word moves, completion pulse at the end of a transfer.
// Assumes: configuration is stable while busy; read data is valid
// one cycle after mem_rd_en (two when cfg_slow_src is set) and held.
module dma_nest_chan
    import dma_nest_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int STEP_W  = 16,
    parameter int BURST_W = 5,
    parameter int XFER_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wide,
    input  logic                     cfg_slow_src,
    input  logic [BURST_W-1:0]       cfg_burst_m1,
    input  logic [XFER_W-1:0]        cfg_xfer_m1,
    input  logic [ADDR_W-1:0]        cfg_src_base,
    input  logic [ADDR_W-1:0]        cfg_dst_base,
    input  logic signed [STEP_W-1:0] cfg_src_wstep,
    input  logic signed [STEP_W-1:0] cfg_dst_wstep,
    input  logic signed [STEP_W-1:0] cfg_src_bstep,
    input  logic signed [STEP_W-1:0] cfg_dst_bstep,
    input  logic                     periph_trig,
    input  logic                     sw_trig,
    output logic                     mem_rd_en,
    output logic                     mem_wr_en,
    output logic                     mem_size,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [WIDE_W-1:0]        mem_wdata,
    input  logic [WIDE_W-1:0]        mem_rdata,
    output logic                     busy,
    output logic                     trig_ovf,
    output logic                     xfer_done_irq
);

    localparam int NPTR = 2;
    localparam int UP_W = WIDE_W - NARROW_W;

    chan_st_e st_q, st_d;
    logic     wait_q;
    logic     in_xfer_q;
    logic     irq_q;
    logic [WIDE_W-1:0] rbuf_q;

    logic ev, pend, launch, new_xfer;
    logic last_word, last_burst, rd_last_wait, xfer_end;

    logic [NPTR-1:0][ADDR_W-1:0]        base_a;
    logic [NPTR-1:0][ADDR_W-1:0]        ptr_a;
    logic [NPTR-1:0][STEP_W-1:0]        wstep_a;
    logic [NPTR-1:0][STEP_W-1:0]        bstep_a;

    assign ev           = periph_trig | sw_trig;
    assign new_xfer     = (st_q == ST_GAP) && !in_xfer_q;
    assign rd_last_wait = (st_q == ST_RWAIT) && !(cfg_slow_src && !wait_q);
    assign xfer_end     = (st_q == ST_ADV) && last_word && last_burst;
    assign launch       = ((st_q == ST_IDLE) && ev) ||
                          ((st_q == ST_ADV) && last_word && (pend || ev));

    // next-state for the word/burst sequencer
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (ev) st_d = ST_GAP;
            ST_GAP:   st_d = ST_RD;
            ST_RD:    st_d = ST_RWAIT;
            ST_RWAIT: if (rd_last_wait) st_d = ST_WR;
            ST_WR:    st_d = ST_ADV;
            ST_ADV:   if (!last_word) st_d = ST_RD;
                      else st_d = (pend || ev) ? ST_GAP : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // sequencer state, slow-source wait bit and transfer-open flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            wait_q    <= 1'b0;
            in_xfer_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            wait_q <= (st_q == ST_RWAIT) && cfg_slow_src && !wait_q;
            if (new_xfer)
                in_xfer_q <= 1'b1;
            else if (xfer_end)
                in_xfer_q <= 1'b0;
        end
    end

    // read-data holding register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (rd_last_wait)
                rbuf_q <= mem_rdata;
            irq_q <= xfer_end;
        end
    end

    // inner loop: words left in the burst
    dma_nest_dcnt #(.W(BURST_W)) u_word_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_q == ST_GAP),
        .dec      (st_q == ST_ADV),
        .load_val (cfg_burst_m1),
        .at_zero  (last_word)
    );

    // outer loop: bursts left in the transfer
    dma_nest_dcnt #(.W(XFER_W)) u_burst_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (new_xfer),
        .dec      ((st_q == ST_ADV) && last_word),
        .load_val (cfg_xfer_m1),
        .at_zero  (last_burst)
    );

    dma_nest_trig u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .busy  (st_q != ST_IDLE),
        .take  (launch),
        .pend  (pend),
        .ovf   (trig_ovf)
    );

    assign base_a  = {cfg_dst_base,  cfg_src_base};
    assign wstep_a = {cfg_dst_wstep, cfg_src_wstep};
    assign bstep_a = {cfg_dst_bstep, cfg_src_bstep};

    // index 0 is the source pointer, index 1 the destination pointer
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_nest_agen #(.AW(ADDR_W), .SW(STEP_W)) u_agen (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (new_xfer),
            .adv        (st_q == ST_ADV),
            .burst_end  (last_word),
            .base       (base_a[g]),
            .word_step  (wstep_a[g]),
            .burst_step (bstep_a[g]),
            .ptr        (ptr_a[g])
        );
    end

    assign mem_rd_en     = (st_q == ST_RD);
    assign mem_wr_en     = (st_q == ST_WR);
    assign mem_size      = cfg_wide;
    assign mem_addr      = (st_q == ST_WR) ? ptr_a[1] : ptr_a[0];
    assign mem_wdata     = cfg_wide ? rbuf_q : {{UP_W{1'b0}}, rbuf_q[NARROW_W-1:0]};
    assign busy          = (st_q != ST_IDLE);
    assign xfer_done_irq = irq_q;

endmodule

// File: rtl/dma_nest_chk.sv
// Protocol checker for the DMA channel, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module dma_nest_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic        cfg_wide,
    input logic [31:0] mem_wdata,
    input logic        trig_ovf,
    input logic        xfer_done_irq
);

    // R4
    rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en && !mem_wr_en));

    // R4
    wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (!mem_wr_en && !mem_rd_en));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R2
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!mem_rd_en && !mem_wr_en));

    // R2
    gap_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> mem_rd_en);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_irq |=> !xfer_done_irq);

    // R11
    ovf_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ovf |-> $past(busy));

    // R6
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !cfg_wide) |-> (mem_wdata[31:16] == 16'h0000));

endmodule

bind dma_nest_chan dma_nest_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_rd_en     (mem_rd_en),
    .mem_wr_en     (mem_wr_en),
    .cfg_wide      (cfg_wide),
    .mem_wdata     (mem_wdata),
    .trig_ovf      (trig_ovf),
    .xfer_done_irq (xfer_done_irq)
);

// File: tb/dma_nest_chan_tb.sv
`timescale 1ns/1ps
module dma_nest_chan_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cfg_wide = 0, cfg_slow_src = 0;
    logic [4:0]  cfg_burst_m1 = 0;
    logic [15:0] cfg_xfer_m1 = 0;
    logic [31:0] cfg_src_base = 0, cfg_dst_base = 0;
    logic signed [15:0] cfg_src_wstep = 0, cfg_dst_wstep = 0;
    logic signed [15:0] cfg_src_bstep = 0, cfg_dst_bstep = 0;
    logic        periph_trig = 0, sw_trig = 0;
    logic        mem_rd_en, mem_wr_en, mem_size, busy, trig_ovf, xfer_done_irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 0;

    dma_nest_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_slow_src(cfg_slow_src),
        .cfg_burst_m1(cfg_burst_m1), .cfg_xfer_m1(cfg_xfer_m1),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
        .cfg_src_wstep(cfg_src_wstep), .cfg_dst_wstep(cfg_dst_wstep),
        .cfg_src_bstep(cfg_src_bstep), .cfg_dst_bstep(cfg_dst_bstep),
        .periph_trig(periph_trig), .sw_trig(sw_trig),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .trig_ovf(trig_ovf), .xfer_done_irq(xfer_done_irq)
    );

    int checks = 0, fails = 0, cyc = 0, rd_cyc = 0;
    int n_wr = 0, n_irq = 0, n_ovf = 0;
    bit done = 0;

    // memory contents as a pure function of the address
    function automatic logic [31:0] mfun(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1234};
    endfunction

    // memory model: one-cycle read latency, data held until next read
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mfun(mem_addr);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct packed {
        logic busy, rd, wr, last;
        logic [31:0] addr, data;
    } ent_t;

    ent_t q[$];
    bit   m_pend = 0, m_inx = 0, exp_irq = 0, exp_ovf = 0;
    logic [31:0] ms = 0, md = 0;
    int   bleft = 0;

    function automatic logic [31:0] sx(logic [15:0] s);
        return {{16{s[15]}}, s};
    endfunction

    function void build_burst();
        ent_t e;
        int nw, nwait;
        if (!m_inx) begin
            ms = cfg_src_base; md = cfg_dst_base; bleft = cfg_xfer_m1; m_inx = 1;
        end
        nw = cfg_burst_m1 + 1;
        nwait = cfg_slow_src ? 2 : 1;
        e = '0; e.busy = 1; q.push_back(e);                       // gap cycle
        for (int w = 0; w < nw; w++) begin
            e = '0; e.busy = 1; e.rd = 1; e.addr = ms; q.push_back(e);
            for (int k = 0; k < nwait; k++) begin
                e = '0; e.busy = 1; q.push_back(e);
            end
            e = '0; e.busy = 1; e.wr = 1; e.addr = md;
            e.data = cfg_wide ? mfun(ms) : {16'h0, mfun(ms) & 32'h0000FFFF} ;
            e.data = cfg_wide ? mfun(ms) : (mfun(ms) & 32'h0000FFFF);
            q.push_back(e);
            e = '0; e.busy = 1; e.last = (w == nw - 1) && (bleft == 0); q.push_back(e);
            if (w < nw - 1) begin
                ms = ms + sx(cfg_src_wstep); md = md + sx(cfg_dst_wstep);
            end else begin
                ms = ms + sx(cfg_src_bstep); md = md + sx(cfg_dst_bstep);
            end
        end
        if (bleft == 0) m_inx = 0; else bleft--;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_pend = 0; m_inx = 0; exp_irq = 0; exp_ovf = 0;
        end else begin
            bit trg, lastx;
            trg = periph_trig | sw_trig;
            lastx = 0;
            exp_irq = 0; exp_ovf = 0;
            if (q.size() != 0) begin
                lastx = q[0].last;
                void'(q.pop_front());
            end
            if (lastx) exp_irq = 1;
            if (trg && m_pend) exp_ovf = 1;
            if (q.size() == 0) begin
                if (m_pend || trg) begin
                    m_pend = 0;
                    build_burst();
                end
            end else if (trg) begin
                m_pend = 1;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        ent_t e;
        cyc++;
        if (rst_n && !done) begin
            e = (q.size() != 0) ? q[0] : '0;
            chk("R2 busy", 32'(busy), 32'(e.busy));
            chk("R4 rd_en", 32'(mem_rd_en), 32'(e.rd));
            chk("R4 wr_en", 32'(mem_wr_en), 32'(e.wr));
            chk("R9 irq", 32'(xfer_done_irq), 32'(exp_irq));
            chk("R11 ovf", 32'(trig_ovf), 32'(exp_ovf));
            if (e.rd || e.wr) begin
                chk("R7 addr", mem_addr, e.addr);
                chk("R6 size", 32'(mem_size), 32'(cfg_wide));
            end
            if (e.wr) chk("R12 data", mem_wdata, e.data);
            if (mem_rd_en) rd_cyc = cyc;
            if (mem_wr_en) begin
                if (cfg_slow_src) chk("R5 rd-to-wr", 32'(cyc - rd_cyc), 32'd3);
                else              chk("R4 rd-to-wr", 32'(cyc - rd_cyc), 32'd2);
                n_wr++;
            end
            if (xfer_done_irq) n_irq++;
            if (trig_ovf) n_ovf++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; periph_trig = 0; sw_trig = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        n_wr = 0; n_irq = 0; n_ovf = 0;
    endtask

    task automatic pulse(input bit use_sw);
        @(negedge clk);
        if (use_sw) sw_trig = 1; else periph_trig = 1;
        @(negedge clk);
        sw_trig = 0; periph_trig = 0;
    endtask

    task automatic settle();
        do @(negedge clk); while (q.size() != 0 || m_pend);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset state
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 rd in reset", 32'(mem_rd_en), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {28'h0, busy, mem_rd_en, mem_wr_en, xfer_done_irq}, 0);
        chk("R1 ovf after reset", 32'(trig_ovf), 0);

        // narrow, 3-word bursts, 2 bursts per transfer, two transfers
        cfg_wide = 0; cfg_slow_src = 0; cfg_burst_m1 = 2; cfg_xfer_m1 = 1;
        cfg_src_base = 32'h0000_1000; cfg_dst_base = 32'h0000_8000;
        cfg_src_wstep = 2; cfg_src_bstep = 100; cfg_dst_wstep = 1; cfg_dst_bstep = -8;
        for (int i = 0; i < 4; i++) begin
            pulse(1);
            settle();
        end
        chk("R3 words moved", n_wr, 12);
        chk("R8 transfers completed", n_irq, 2);

        // wide, slow source, single-word bursts, triple trigger
        do_reset();
        cfg_wide = 1; cfg_slow_src = 1; cfg_burst_m1 = 0; cfg_xfer_m1 = 2;
        cfg_src_base = 32'h0002_0000; cfg_dst_base = 32'h0004_0010;
        cfg_src_wstep = -4; cfg_src_bstep = -16; cfg_dst_wstep = 4; cfg_dst_bstep = -2;
        @(negedge clk);
        periph_trig = 1;
        repeat (3) @(negedge clk);
        periph_trig = 0;
        settle();
        chk("R10 pending burst ran", n_wr, 2);
        chk("R11 overflow count", n_ovf, 1);
        chk("R8 not yet complete", n_irq, 0);
        pulse(0);
        settle();
        chk("R9 single completion", n_irq, 1);

        // full 32-word burst, one-burst transfer
        do_reset();
        cfg_wide = 1; cfg_slow_src = 0; cfg_burst_m1 = 31; cfg_xfer_m1 = 0;
        cfg_src_base = 32'hFFFF_FFF0; cfg_dst_base = 32'h0000_0100;
        cfg_src_wstep = 1; cfg_src_bstep = 7; cfg_dst_wstep = -1; cfg_dst_bstep = 3;
        pulse(1);
        settle();
        chk("R3 32-word burst", n_wr, 32);
        chk("R9 one irq", n_irq, 1);

        // trigger sweep: every spacing hits a different burst phase
        for (int k = 1; k <= 10; k++) begin
            do_reset();
            cfg_wide = k[0]; cfg_slow_src = k[1]; cfg_burst_m1 = 1; cfg_xfer_m1 = 3;
            cfg_src_base = 32'h100 * k; cfg_dst_base = 32'h9000 + k;
            cfg_src_wstep = 16'(k); cfg_src_bstep = -16'(k);
            cfg_dst_wstep = 3; cfg_dst_bstep = 5;
            for (int p = 0; p < 6; p++) begin
                pulse(p[0]);
                repeat (k - 1) @(negedge clk);
            end
            settle();
        end

        finish_run();
    end

endmodule